// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block holds the program-counter pair of a 32-bit RISC core in which every control transfer has one delay slot: `pc` is the address of the instruction being handled now and `npc` is the address of the instruction after it. On each cycle with `step` high, the core presents the instruction at `pc` along with the integer flags N, Z, V and C. For a register-indirect jump it also presents the sum of the jump's two operands. The block then loads the new pair. A delayed branch moves `npc` into `pc` and loads the branch target into `npc`, so the instruction that follows the branch runs before control arrives at the target.

A branch can carry an annul bit. For the never and always conditions the annul bit skips the delay slot outright, with no squashed cycle. For the fourteen flag-tested conditions it works the other way: the delay slot runs when the branch is taken, and is squashed when the branch is not taken. The squashed instruction is still stepped through, but it has no effect. Call and jump-and-link also raise a link-register write request, in the same cycle, carrying the address of the transfer instruction. An externally decoded illegal-instruction indication is passed through, and is masked while the current instruction is squashed.

The sequencer is a two-state machine. RUN is the normal state. SQUASH marks the current instruction as nullified. Transitions: RUN→RUN on any stepped instruction that does not leave a squash pending. RUN→SQUASH on a stepped conditional branch that is not taken and has its annul bit set. SQUASH→RUN on the next stepped instruction, whatever that instruction is. Every state holds while `step` is low.

Top module: `dslot_pc_seq`

## Requirements
- R1: After reset, `pc` equals RESET_PC (default 0), `npc` equals RESET_PC+4, the state is RUN (`squash` low), and `link_we` is low.
- R2: A stepped instruction that is not a transfer, or a squashed one, sets `pc` to the old `npc` and `npc` to the old `npc`+4. While `step` is low, `pc`, `npc` and `squash` hold.
- R3: A branch is a word with bits[31:30]=00 and bits[24:22]=010. Its condition code is bits[28:25], its annul bit is bit 29, and its target is `pc` plus bits[21:0] shifted left by 2 and sign-extended. An op-00 word with a different bits[24:22] is not a transfer.
- R4: Condition 0 (never): without annul the step is sequential. With annul, `pc` becomes old `npc`+4 and `npc` becomes old `npc`+8, and no squash is raised.
- R5: Condition 8 (always): without annul, `pc` becomes old `npc` and `npc` becomes the target. With annul, `pc` becomes the target and `npc` becomes the target+4, and no squash is raised.
- R6: A flag-tested branch (any condition other than 0 and 8) that is taken sets `pc` to old `npc` and `npc` to the target, and raises no squash, whatever its annul bit.
- R7: A flag-tested branch that is not taken steps sequentially. If its annul bit is set, the machine enters SQUASH and `squash` is high for the next instruction.
- R8: Condition codes evaluate as: 1 Z; 2 Z|(N^V); 3 N^V; 4 C|Z; 5 C; 6 N; 7 V. Codes 9 to F are the complements of codes 1 to 7 in the same order.
- R9: A call (bits[31:30]=01) raises `link_we` with `link_addr`=15 and `link_data`=`pc` in the cycle it is stepped. It sets `pc` to old `npc`, and `npc` to old `pc` plus bits[29:0] shifted left by 2.
- R10: A jump-and-link (bits[31:30]=10, bits[24:19]=111000) sets `pc` to old `npc` and `npc` to `jump_sum`. When rd (bits[29:25]) is non-zero it raises `link_we` with `link_addr`=rd and `link_data`=`pc`. When rd is zero it raises no link write.
- R11: A squashed instruction raises no link write and starts no transfer. `squash` lasts exactly one stepped instruction.
- R12: `illegal_out` equals `illegal_in` while `step` is high and the current instruction is not squashed. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | The instruction at `pc` is handled this cycle |
| insn | input | 32 | Instruction word at `pc` |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| jump_sum | input | 32 | Operand sum for a register-indirect jump |
| illegal_in | input | 1 | Illegal-instruction indication from decode |
| pc | output | 32 | Address of the current instruction |
| npc | output | 32 | Address of the following instruction |
| squash | output | 1 | Current instruction is nullified |
| link_we | output | 1 | Link register write request |
| link_addr | output | 5 | Link register index |
| link_data | output | 32 | Return address (address of the transfer) |
| illegal_out | output | 1 | Masked illegal-instruction indication |

## Verification
`link_we`, `link_addr`, `link_data` and `illegal_out` follow the stepped instruction in the same cycle. The bench samples them one nanosecond after it drives the inputs, which is still before the next rising edge. `pc`, `npc` and `squash` are registered, so their new values appear one edge after the step. The bench checks them at the following falling edge, against a reference model that it advances once per stepped instruction. A squash raised by an annulled branch is checked on the next instruction stepped after the branch, and its clearing on the instruction after that.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [1:0] {
        XF_NONE   = 2'd0,
        XF_BRANCH = 2'd1,
        XF_CALL   = 2'd2,
        XF_JUMP   = 2'd3
    } xfer_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_SQUASH = 1'b1
    } seq_state_e;

    localparam logic [1:0] OP_BRANCH_GRP = 2'b00;
    localparam logic [1:0] OP_CALL       = 2'b01;
    localparam logic [1:0] OP_ARITH_GRP  = 2'b10;
    localparam logic [2:0] SUB_BRANCH    = 3'b010;
    localparam logic [5:0] SUB_JUMP_LINK = 6'h38;
    localparam logic [3:0] COND_NEVER    = 4'h0;
    localparam logic [3:0] COND_ALWAYS   = 4'h8;
    localparam logic [4:0] CALL_LINK_REG = 5'd15;

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
    import pcs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [31:0]   insn,
    output xfer_e         kind,
    output logic [3:0]    cond,
    output logic          annul,
    output logic [4:0]    rd,
    output logic [AW-1:0] br_off,
    output logic [AW-1:0] call_off
);
    localparam int BR_W   = 24;
    localparam int CALL_W = 32;

    logic [BR_W-1:0]   br_scaled;
    logic [CALL_W-1:0] call_scaled;

    assign br_scaled   = {insn[21:0], 2'b00};
    assign call_scaled = {insn[29:0], 2'b00};
    assign cond        = insn[28:25];
    assign annul       = insn[29];
    assign rd          = insn[29:25];

    generate
        if (AW > BR_W) begin : g_br_ext
            assign br_off = {{(AW-BR_W){br_scaled[BR_W-1]}}, br_scaled};
        end else begin : g_br_trunc
            assign br_off = br_scaled[AW-1:0];
        end
        if (AW > CALL_W) begin : g_call_ext
            assign call_off = {{(AW-CALL_W){call_scaled[CALL_W-1]}}, call_scaled};
        end else begin : g_call_trunc
            assign call_off = call_scaled[AW-1:0];
        end
    endgenerate

    always_comb begin
        kind = XF_NONE;
        unique case (insn[31:30])
            OP_BRANCH_GRP: if (insn[24:22] == SUB_BRANCH) kind = XF_BRANCH;
            OP_CALL:       kind = XF_CALL;
            OP_ARITH_GRP:  if (insn[24:19] == SUB_JUMP_LINK) kind = XF_JUMP;
            default:       kind = XF_NONE;
        endcase
    end

endmodule

// File: rtl/pcs_cond_eval.sv
module pcs_cond_eval (
    input  logic [3:0] cond,
    input  logic       fn,
    input  logic       fz,
    input  logic       fv,
    input  logic       fc,
    output logic       taken
);
    logic base;
    logic signed_lt;

    assign signed_lt = fn ^ fv;

    always_comb begin
        unique case (cond[2:0])
            3'd0: base = 1'b0;
            3'd1: base = fz;
            3'd2: base = fz | signed_lt;
            3'd3: base = signed_lt;
            3'd4: base = fc | fz;
            3'd5: base = fc;
            3'd6: base = fn;
            3'd7: base = fv;
            default: base = 1'b0;
        endcase
    end

    assign taken = base ^ cond[3];

endmodule

// File: rtl/pcs_next_addr.sv
module pcs_next_addr
    import pcs_pkg::*;
#(
    parameter int AW = 32
) (
    input  xfer_e         kind,
    input  logic [3:0]    cond,
    input  logic          annul,
    input  logic          taken,
    input  logic [AW-1:0] pc_cur,
    input  logic [AW-1:0] npc_cur,
    input  logic [AW-1:0] br_off,
    input  logic [AW-1:0] call_off,
    input  logic [AW-1:0] jump_sum,
    output logic [AW-1:0] pc_nx,
    output logic [AW-1:0] npc_nx,
    output logic          squash_set
);
    localparam logic [AW-1:0] WORD = AW'(4);

    logic [AW-1:0] br_target;
    logic [AW-1:0] seq_npc;

    assign br_target = pc_cur + br_off;
    assign seq_npc   = npc_cur + WORD;

    always_comb begin
        pc_nx      = npc_cur;
        npc_nx     = seq_npc;
        squash_set = 1'b0;
        unique case (kind)
            XF_BRANCH: begin
                if (cond == COND_NEVER) begin
                    if (annul) begin
                        pc_nx  = seq_npc;
                        npc_nx = seq_npc + WORD;
                    end
                end else if (cond == COND_ALWAYS) begin
                    if (annul) begin
                        pc_nx  = br_target;
                        npc_nx = br_target + WORD;
                    end else begin
                        npc_nx = br_target;
                    end
                end else if (taken) begin
                    npc_nx = br_target;
                end else begin
                    squash_set = annul;
                end
            end
            XF_CALL:  npc_nx = pc_cur + call_off;
            XF_JUMP:  npc_nx = jump_sum;
            default:  npc_nx = seq_npc;
        endcase
    end

endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
    import pcs_pkg::*;
#(
    parameter int          AW       = 32,
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [31:0]   insn,
    input  logic          flag_n,
    input  logic          flag_z,
    input  logic          flag_v,
    input  logic          flag_c,
    input  logic [AW-1:0] jump_sum,
    input  logic          illegal_in,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] npc,
    output logic          squash,
    output logic          link_we,
    output logic [4:0]    link_addr,
    output logic [AW-1:0] link_data,
    output logic          illegal_out
);
    localparam logic [AW-1:0] WORD     = AW'(4);
    localparam logic [AW-1:0] BOOT_PC  = RESET_PC[AW-1:0];
    localparam logic [AW-1:0] BOOT_NPC = BOOT_PC + WORD;

    seq_state_e    state_q, state_d;
    logic [AW-1:0] pc_q, npc_q, pc_d, npc_d;

    xfer_e         kind;
    logic [3:0]    cond;
    logic          annul;
    logic [4:0]    rd;
    logic [AW-1:0] br_off, call_off;
    logic          taken;
    logic [AW-1:0] pc_nx, npc_nx;
    logic          squash_set;

    pcs_decode #(.AW(AW)) u_decode (
        .insn     (insn),
        .kind     (kind),
        .cond     (cond),
        .annul    (annul),
        .rd       (rd),
        .br_off   (br_off),
        .call_off (call_off)
    );

    pcs_cond_eval u_cond (
        .cond  (cond),
        .fn    (flag_n),
        .fz    (flag_z),
        .fv    (flag_v),
        .fc    (flag_c),
        .taken (taken)
    );

    pcs_next_addr #(.AW(AW)) u_next (
        .kind       (kind),
        .cond       (cond),
        .annul      (annul),
        .taken      (taken),
        .pc_cur     (pc_q),
        .npc_cur    (npc_q),
        .br_off     (br_off),
        .call_off   (call_off),
        .jump_sum   (jump_sum),
        .pc_nx      (pc_nx),
        .npc_nx     (npc_nx),
        .squash_set (squash_set)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pc_q    <= BOOT_PC;
            npc_q   <= BOOT_NPC;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            npc_q   <= npc_d;
        end
    end

    // Next-state and output logic
    always_comb begin
        state_d     = state_q;
        pc_d        = pc_q;
        npc_d       = npc_q;
        link_we     = 1'b0;
        link_addr   = '0;
        link_data   = '0;
        illegal_out = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (step) begin
                    pc_d        = pc_nx;
                    npc_d       = npc_nx;
                    state_d     = squash_set ? ST_SQUASH : ST_RUN;
                    illegal_out = illegal_in;
                    if (kind == XF_CALL) begin
                        link_we   = 1'b1;
                        link_addr = CALL_LINK_REG;
                        link_data = pc_q;
                    end else if (kind == XF_JUMP && rd != 5'd0) begin
                        link_we   = 1'b1;
                        link_addr = rd;
                        link_data = pc_q;
                    end
                end
            end
            ST_SQUASH: begin
                if (step) begin
                    pc_d    = npc_q;
                    npc_d   = npc_q + WORD;
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign pc     = pc_q;
    assign npc    = npc_q;
    assign squash = (state_q == ST_SQUASH);

    AST_RESET_PAIR: assert property (@(posedge clk)
        $past(!rst_n) |-> (pc == BOOT_PC && npc == BOOT_NPC && !squash)); // R1

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (squash || kind == XF_NONE)) |=>
        (pc == $past(npc) && npc == $past(npc) + WORD)); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(pc) && $stable(npc) && $stable(squash))); // R2

    AST_ANNUL_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !squash && kind == XF_BRANCH && cond != COND_NEVER &&
         cond != COND_ALWAYS && !taken && annul) |=> squash); // R7

    AST_TAKEN_NO_SQ: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !squash && kind == XF_BRANCH && taken) |=> !squash); // R6

    AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !squash && kind == XF_CALL) |->
        (link_we && link_addr == CALL_LINK_REG && link_data == pc)); // R9

    AST_SQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && squash) |=> !squash); // R11

    AST_SQ_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> (!link_we && !illegal_out)); // R11

endmodule

// File: tb/test_dslot_pc_seq.sv
`timescale 1ns/1ps
module test_dslot_pc_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [31:0] insn = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
    logic [31:0] jump_sum = '0;
    logic        illegal_in = 1'b0;
    logic [31:0] pc, npc, link_data;
    logic        squash, link_we, illegal_out;
    logic [4:0]  link_addr;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_pc, m_npc;
    logic        m_sq;
    string       last_tag = "R1";

    always #2 clk = ~clk;

    dslot_pc_seq i_dslot_pc_seq (
        .clk(clk), .rst_n(rst_n), .step(step), .insn(insn),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .jump_sum(jump_sum), .illegal_in(illegal_in),
        .pc(pc), .npc(npc), .squash(squash),
        .link_we(link_we), .link_addr(link_addr), .link_data(link_data),
        .illegal_out(illegal_out)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_br(logic a, logic [3:0] c, logic [21:0] d);
        return {2'b00, a, c, 3'b010, d};
    endfunction
    function automatic logic [31:0] mk_call(logic [29:0] d);
        return {2'b01, d};
    endfunction
    function automatic logic [31:0] mk_jmpl(logic [4:0] r);
        return {2'b10, r, 6'h38, 19'h0};
    endfunction
    localparam logic [31:0] ALU_OP  = {2'b10, 5'd3, 6'h02, 19'h1234};
    localparam logic [31:0] HI_LOAD = {2'b00, 5'd4, 3'b100, 22'h2ABCD};

    function automatic logic ref_cond(logic [3:0] c, logic [3:0] f);
        logic n, z, v, cy;
        {n, z, v, cy} = f;
        case (c)
            4'h0: return 1'b0;
            4'h1: return z;
            4'h2: return z | (n ^ v);
            4'h3: return n ^ v;
            4'h4: return cy | z;
            4'h5: return cy;
            4'h6: return n;
            4'h7: return v;
            4'h8: return 1'b1;
            4'h9: return !z;
            4'hA: return !(z | (n ^ v));
            4'hB: return !(n ^ v);
            4'hC: return !(cy | z);
            4'hD: return !cy;
            4'hE: return !n;
            default: return !v;
        endcase
    endfunction

    task automatic check_regs();
        check(last_tag, "pc", pc, m_pc);
        check(last_tag, "npc", npc, m_npc);
        check(last_tag, "squash", {31'b0, squash}, {31'b0, m_sq});
    endtask

    // flags order: {N,Z,V,C}
    task automatic do_step(string tag, logic [31:0] w, logic [3:0] f, logic [31:0] js, logic ill);
        logic        exp_we;
        logic [4:0]  exp_ad;
        logic [31:0] tgt;
        logic [23:0] d24;
        @(negedge clk);
        check_regs();
        step = 1'b1; insn = w; {flag_n, flag_z, flag_v, flag_c} = f;
        jump_sum = js; illegal_in = ill;
        #1;
        exp_we = 1'b0; exp_ad = 5'd0;
        if (!m_sq && w[31:30] == 2'b01) begin exp_we = 1'b1; exp_ad = 5'd15; end
        if (!m_sq && w[31:30] == 2'b10 && w[24:19] == 6'h38 && w[29:25] != 0) begin
            exp_we = 1'b1; exp_ad = w[29:25];
        end
        check(tag, "link_we", {31'b0, link_we}, {31'b0, exp_we});
        if (exp_we) begin
            check(tag, "link_addr", {27'b0, link_addr}, {27'b0, exp_ad});
            check(tag, "link_data", link_data, m_pc);
        end
        check(tag, "illegal_out", {31'b0, illegal_out}, {31'b0, ill & !m_sq});
        // reference update
        if (m_sq) begin
            m_pc = m_npc; m_npc = m_npc + 4; m_sq = 1'b0;
        end else if (w[31:30] == 2'b00 && w[24:22] == 3'b010) begin
            d24 = {w[21:0], 2'b00};
            tgt = m_pc + {{8{d24[23]}}, d24};
            if (w[28:25] == 4'h0) begin
                if (w[29]) begin m_pc = m_npc + 4; m_npc = m_npc + 8; end
                else begin m_pc = m_npc; m_npc = m_npc + 4; end
            end else if (w[28:25] == 4'h8) begin
                if (w[29]) begin m_pc = tgt; m_npc = tgt + 4; end
                else begin m_pc = m_npc; m_npc = tgt; end
            end else if (ref_cond(w[28:25], f)) begin
                m_pc = m_npc; m_npc = tgt;
            end else begin
                m_pc = m_npc; m_npc = m_npc + 4; m_sq = w[29];
            end
        end else if (w[31:30] == 2'b01) begin
            tgt = m_pc + {w[29:0], 2'b00};
            m_pc = m_npc; m_npc = tgt;
        end else if (w[31:30] == 2'b10 && w[24:19] == 6'h38) begin
            m_pc = m_npc; m_npc = js;
        end else begin
            m_pc = m_npc; m_npc = m_npc + 4;
        end
        last_tag = tag;
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        check_regs();
        step = 1'b0; illegal_in = 1'b1;
        #1;
        check(tag, "link_we idle", {31'b0, link_we}, 32'd0);
        check(tag, "illegal_out idle", {31'b0, illegal_out}, 32'd0);
        illegal_in = 1'b0;
        last_tag = tag;
    endtask

    initial begin : watchdog
        #800000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        m_pc = 32'h0; m_npc = 32'h4; m_sq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset pc", pc, 32'h0);
        check("R1", "reset npc", npc, 32'h4);
        check("R1", "reset squash", {31'b0, squash}, 32'd0);
        check("R1", "reset link_we", {31'b0, link_we}, 32'd0);
        last_tag = "R1";

        // R2 sequential flow and hold
        do_step("R2", ALU_OP, 4'h0, 32'h0, 1'b0);
        do_step("R2", ALU_OP, 4'hF, 32'h0, 1'b0);
        idle("R2");
        idle("R2");
        do_step("R2", ALU_OP, 4'h0, 32'h0, 1'b0);
        // R3 non-branch op-00 word, far negative displacement
        do_step("R3", HI_LOAD, 4'h0, 32'h0, 1'b0);
        do_step("R3", mk_br(1'b0, 4'h8, 22'h3FFFF0), 4'h0, 32'h0, 1'b0);
        do_step("R3", ALU_OP, 4'h0, 32'h0, 1'b0);
        // R4 never
        do_step("R4", mk_br(1'b0, 4'h0, 22'h40), 4'hF, 32'h0, 1'b0);
        do_step("R4", mk_br(1'b1, 4'h0, 22'h40), 4'hF, 32'h0, 1'b0);
        do_step("R4", ALU_OP, 4'h0, 32'h0, 1'b0);
        // R5 always
        do_step("R5", mk_br(1'b0, 4'h8, 22'h10), 4'h0, 32'h0, 1'b0);
        do_step("R5", ALU_OP, 4'h0, 32'h0, 1'b0);
        do_step("R5", mk_br(1'b1, 4'h8, 22'h3FFFFC), 4'h0, 32'h0, 1'b0);
        do_step("R5", ALU_OP, 4'h0, 32'h0, 1'b0);
        // R6 taken with annul set
        do_step("R6", mk_br(1'b1, 4'h1, 22'h20), 4'b0100, 32'h0, 1'b0);
        do_step("R6", ALU_OP, 4'h0, 32'h0, 1'b0);
        // R7 not taken, no annul then annul
        do_step("R7", mk_br(1'b0, 4'h1, 22'h20), 4'b0000, 32'h0, 1'b0);
        do_step("R7", mk_br(1'b1, 4'h1, 22'h20), 4'b0000, 32'h0, 1'b0);
        // R11 squashed call and illegal have no effect, one shot
        do_step("R11", mk_call(30'h100), 4'h0, 32'h0, 1'b1);
        idle("R11");
        do_step("R11", ALU_OP, 4'h0, 32'h0, 1'b0);
        // squashed jump and squashed branch
        do_step("R11", mk_br(1'b1, 4'h9, 22'h8), 4'b0100, 32'h0, 1'b0);
        do_step("R11", mk_jmpl(5'd9), 4'h0, 32'hDEAD_BEE0, 1'b0);
        do_step("R11", mk_br(1'b1, 4'h3, 22'h8), 4'b0000, 32'h0, 1'b0);
        do_step("R11", mk_br(1'b1, 4'h8, 22'h30), 4'h0, 32'h0, 1'b0);
        do_step("R11", ALU_OP, 4'h0, 32'h0, 1'b0);
        // R9 calls
        do_step("R9", mk_call(30'h40), 4'h0, 32'h0, 1'b0);
        do_step("R9", ALU_OP, 4'h0, 32'h0, 1'b0);
        do_step("R9", mk_call(30'h3FFFFFF0), 4'h0, 32'h0, 1'b0);
        do_step("R9", ALU_OP, 4'h0, 32'h0, 1'b0);
        // R10 jump-and-link
        do_step("R10", mk_jmpl(5'd0), 4'h0, 32'h0000_2000, 1'b0);
        do_step("R10", ALU_OP, 4'h0, 32'h0, 1'b0);
        do_step("R10", mk_jmpl(5'd7), 4'h0, 32'h0000_3100, 1'b0);
        do_step("R10", ALU_OP, 4'h0, 32'h0, 1'b0);
        // R12 illegal pass-through
        do_step("R12", ALU_OP, 4'h0, 32'h0, 1'b1);
        do_step("R12", ALU_OP, 4'h0, 32'h0, 1'b0);
        // R8 full condition sweep, annul alternating
        for (int c = 1; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                do_step("R8", mk_br(f[0], c[3:0], 22'h6), f[3:0], 32'h0, 1'b0);
                do_step("R8", ALU_OP, 4'h0, 32'h0, 1'b0);
            end
        end
        @(negedge clk);
        check_regs();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule